// File: doc/BRIEF.md
# ADC Scan-Mode Conversion Sequencer

This block is the digital controller for a multi-channel successive-approximation A/D converter that runs in continuous scan mode. Software or an external trigger holds a run bit high. While it is high, the sequencer steps through one to four channels of a selected group, in ascending order. For each channel it drives the channel number, a one-cycle sample strobe and a convert level to an abstracted converter core. The core answers with a done pulse and a result word. When a conversion's time runs out, the sequencer stores the most recently returned result in that channel's data register. After the last channel of the group it sets a sticky completion flag and, if enabled, requests an interrupt. It then wraps to the group's first channel without any software action.

The first conversion after the run bit rises also covers a start delay of `START_DELAY` cycles. Every conversion after that, including those after a wrap, lasts a fixed time. That time is `CONV_SLOW` (266) cycles with the clock select at 0, or `CONV_FAST` (134) cycles with it at 1. The group select and the scan size are captured when a scan starts. The clock select is read at the start of each conversion.

The controller has three states. IDLE waits for the run bit. DELAY counts the start delay. CONV counts one conversion. The transitions are as follows:
- start: IDLE to DELAY when the run bit is seen high.
- delay-done: DELAY to CONV.
- conversion-end: CONV to CONV, which writes the result and moves to the next channel.
- abort: DELAY or CONV to IDLE when the run bit is low.

Top module: `adc_scan_sequencer`

## Requirements
- R1: After reset, `flag_o`, `irq_o`, `sample_o` and `convert_o` are 0, `chan_o` is 0 and every result register reads 0.
- R2: With `grp_sel_i` = 0 a scan starts at channel 0; with `grp_sel_i` = 1 it starts at channel `GROUP_CH` (4).
- R3: A `scan_size_i` code of n selects n+1 channels, converted in ascending order from the group's first channel; `chan_o` shows the channel being converted.
- R4: At the end of each conversion, the result word returned by the core during that conversion is written to the result register of that channel only, at bit slice `[ch*RES_W +: RES_W]` of `results_o`.
- R5: The first conversion after the run bit is sampled high ends `START_DELAY + conversion length` cycles after that sampling edge; `sample_o` and `convert_o` stay 0 during the delay.
- R6: Every later conversion lasts exactly 266 cycles when `clk_sel_i` = 0 and 134 cycles when `clk_sel_i` = 1.
- R7: `flag_o` rises on the edge that ends the conversion of the last selected channel, and not before.
- R8: `irq_o` rises together with `flag_o` when `irq_en_i` = 1 and stays 0 when `irq_en_i` = 0.
- R9: After the last channel, scanning wraps to the group's first channel and starts a new conversion in the next cycle, as long as the run bit stays 1.
- R10: `flag_o` stays 1 until a one-cycle `flag_clr_i` pulse; that pulse also clears `irq_o`. If a flag set and a clear fall in the same cycle, the set wins.
- R11: Driving `start_i` to 0 in DELAY or CONV returns the block to IDLE on the next edge (`convert_o` = 0) without writing any result register. A later start begins again with the start delay.
- R12: `sample_o` is a one-cycle pulse in the first cycle of every conversion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Run bit; scanning runs while it is 1 |
| grp_sel_i | input | 1 | Group select: 0 lower group, 1 upper group |
| clk_sel_i | input | 1 | Conversion speed: 0 slow (266), 1 fast (134) |
| irq_en_i | input | 1 | Interrupt enable |
| scan_size_i | input | 2 | Number of channels in the scan, minus one |
| flag_clr_i | input | 1 | One-cycle pulse that clears the completion flag and interrupt |
| core_done_i | input | 1 | Converter core result-valid pulse |
| core_data_i | input | RES_W (10) | Converter core result word |
| chan_o | output | 3 | Channel under conversion |
| sample_o | output | 1 | Sample strobe, first cycle of a conversion |
| convert_o | output | 1 | High while a conversion is in progress |
| flag_o | output | 1 | Sticky scan-complete flag |
| irq_o | output | 1 | Interrupt request |
| results_o | output | 8*RES_W (80) | All channel result registers, channel 0 in the low bits |

## Verification
Call the edge that samples the run bit high edge 0, and let L be the active conversion length. Then `sample_o` is first due after edge D = `START_DELAY`. The result of scan position j lands after edge D + (j+1)·L, and the flag and interrupt land with the last position's write. The bench keeps a free-running edge count and samples on the falling edge both one edge before and exactly at each due edge. This catches a result, flag or strobe that arrives one cycle early or late. Abort checks read the result registers past the edge where the cancelled write would have fallen, and a restart checks that the full start delay is counted again.

// File: rtl/adc_scan_pkg.sv
`timescale 1ns/1ps
package adc_scan_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_DELAY = 2'd1,
        ST_CONV  = 2'd2
    } scan_state_e;

    function automatic int max3(input int a, input int b, input int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/adc_scan_timer.sv
`timescale 1ns/1ps
module adc_scan_timer #(
    parameter int TMR_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [TMR_W-1:0] load_val_i,
    output logic             done_o
);

    logic [TMR_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= load_val_i;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign done_o = (cnt_q == '0);

    // R6: the count steps down by exactly one per cycle between loads
    p_count_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));

endmodule

// File: rtl/adc_scan_chan_ptr.sv
`timescale 1ns/1ps
module adc_scan_chan_ptr #(
    parameter int GROUP_CH = 4,
    parameter int OFF_W    = 2,
    parameter int CH_W     = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart_i,
    input  logic             grp_i,
    input  logic [OFF_W-1:0] size_i,
    input  logic             advance_i,
    output logic [CH_W-1:0]  chan_o,
    output logic             last_o
);

    localparam logic [OFF_W-1:0] MAX_OFF = OFF_W'(GROUP_CH - 1);

    logic             grp_q;
    logic [OFF_W-1:0] size_q;
    logic [OFF_W-1:0] off_q;
    logic [OFF_W-1:0] size_clamped;

    assign size_clamped = (size_i > MAX_OFF) ? MAX_OFF : size_i;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            grp_q  <= 1'b0;
            size_q <= '0;
            off_q  <= '0;
        end else if (restart_i) begin
            grp_q  <= grp_i;
            size_q <= size_clamped;
            off_q  <= '0;
        end else if (advance_i) begin
            off_q <= last_o ? '0 : off_q + 1'b1;
        end
    end

    assign last_o = (off_q == size_q);
    assign chan_o = grp_q ? (CH_W'(GROUP_CH) + CH_W'(off_q)) : CH_W'(off_q);

    // R3: the scan position never passes the selected size
    p_off_in_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
        off_q <= size_q);

    // R9: advancing from the last position wraps to the first channel
    p_wrap_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (advance_i && last_o && !restart_i) |=> (off_q == '0));

endmodule

// File: rtl/adc_scan_result_bank.sv
`timescale 1ns/1ps
module adc_scan_result_bank #(
    parameter int NUM_CH = 8,
    parameter int CH_W   = 3,
    parameter int RES_W  = 10
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en_i,
    input  logic [CH_W-1:0]         wr_idx_i,
    input  logic [RES_W-1:0]        wr_data_i,
    output logic [NUM_CH*RES_W-1:0] results_o
);

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_slot
        logic [RES_W-1:0] val_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                val_q <= '0;
            end else if (wr_en_i && wr_idx_i == CH_W'(ch)) begin
                val_q <= wr_data_i;
            end
        end

        assign results_o[ch*RES_W +: RES_W] = val_q;
    end

    // R4 / R11: without a write strobe no result register changes
    p_hold_without_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en_i |=> $stable(results_o));

endmodule

// File: rtl/adc_scan_sequencer.sv
`timescale 1ns/1ps
module adc_scan_sequencer #(
    parameter int GROUP_CH    = 4,
    parameter int RES_W       = 10,
    parameter int START_DELAY = 10,
    parameter int CONV_SLOW   = 266,
    parameter int CONV_FAST   = 134
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      start_i,
    input  logic                      grp_sel_i,
    input  logic                      clk_sel_i,
    input  logic                      irq_en_i,
    input  logic [1:0]                scan_size_i,
    input  logic                      flag_clr_i,
    input  logic                      core_done_i,
    input  logic [RES_W-1:0]          core_data_i,
    output logic [2:0]                chan_o,
    output logic                      sample_o,
    output logic                      convert_o,
    output logic                      flag_o,
    output logic                      irq_o,
    output logic [2*GROUP_CH*RES_W-1:0] results_o
);

    import adc_scan_pkg::*;

    localparam int NUM_CH  = 2 * GROUP_CH;
    localparam int CH_W    = $clog2(NUM_CH);
    localparam int OFF_W   = (GROUP_CH > 1) ? $clog2(GROUP_CH) : 1;
    localparam int MAX_CNT = max3(START_DELAY, CONV_SLOW, CONV_FAST);
    localparam int TMR_W   = $clog2(MAX_CNT + 1);

    localparam logic [TMR_W-1:0] DELAY_M1 = TMR_W'(START_DELAY - 1);
    localparam logic [TMR_W-1:0] SLOW_M1  = TMR_W'(CONV_SLOW - 1);
    localparam logic [TMR_W-1:0] FAST_M1  = TMR_W'(CONV_FAST - 1);

    scan_state_e state_q, state_d;

    logic             tmr_load;
    logic [TMR_W-1:0] tmr_val;
    logic             tmr_done;
    logic             ptr_restart;
    logic             ptr_advance;
    logic             ptr_last;
    logic [CH_W-1:0]  chan;
    logic             conv_end;
    logic             enter_conv;
    logic [TMR_W-1:0] conv_len_m1;
    logic [RES_W-1:0] hold_q;
    logic             sample_q;
    logic             flag_q;
    logic             irq_q;
    logic             scan_done;

    assign conv_len_m1 = clk_sel_i ? FAST_M1 : SLOW_M1;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state and control strobes
    always_comb begin
        state_d     = state_q;
        tmr_load    = 1'b0;
        tmr_val     = '0;
        ptr_restart = 1'b0;
        ptr_advance = 1'b0;
        conv_end    = 1'b0;
        enter_conv  = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (start_i) begin
                    state_d     = ST_DELAY;
                    tmr_load    = 1'b1;
                    tmr_val     = DELAY_M1;
                    ptr_restart = 1'b1;
                end
            end
            ST_DELAY: begin
                if (!start_i) begin
                    state_d = ST_IDLE;
                end else if (tmr_done) begin
                    state_d    = ST_CONV;
                    tmr_load   = 1'b1;
                    tmr_val    = conv_len_m1;
                    enter_conv = 1'b1;
                end
            end
            ST_CONV: begin
                if (!start_i) begin
                    state_d = ST_IDLE;
                end else if (tmr_done) begin
                    conv_end    = 1'b1;
                    ptr_advance = 1'b1;
                    tmr_load    = 1'b1;
                    tmr_val     = conv_len_m1;
                    enter_conv  = 1'b1;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    assign scan_done = conv_end && ptr_last;

    // Output registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sample_q <= 1'b0;
            flag_q   <= 1'b0;
            irq_q    <= 1'b0;
            hold_q   <= '0;
        end else begin
            sample_q <= enter_conv;
            if (core_done_i) begin
                hold_q <= core_data_i;
            end
            if (scan_done) begin
                flag_q <= 1'b1;
                if (irq_en_i) begin
                    irq_q <= 1'b1;
                end
            end else if (flag_clr_i) begin
                flag_q <= 1'b0;
                irq_q  <= 1'b0;
            end
        end
    end

    assign sample_o  = sample_q;
    assign convert_o = (state_q == ST_CONV);
    assign flag_o    = flag_q;
    assign irq_o     = irq_q;
    assign chan_o    = 3'(chan);

    adc_scan_timer #(
        .TMR_W (TMR_W)
    ) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (tmr_load),
        .load_val_i (tmr_val),
        .done_o     (tmr_done)
    );

    adc_scan_chan_ptr #(
        .GROUP_CH (GROUP_CH),
        .OFF_W    (OFF_W),
        .CH_W     (CH_W)
    ) u_chan_ptr (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart_i (ptr_restart),
        .grp_i     (grp_sel_i),
        .size_i    (OFF_W'(scan_size_i)),
        .advance_i (ptr_advance),
        .chan_o    (chan),
        .last_o    (ptr_last)
    );

    adc_scan_result_bank #(
        .NUM_CH (NUM_CH),
        .CH_W   (CH_W),
        .RES_W  (RES_W)
    ) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (conv_end),
        .wr_idx_i  (chan),
        .wr_data_i (hold_q),
        .results_o (results_o)
    );

    // R11: a low run bit outside IDLE always leads back to IDLE
    p_abort_to_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE && !start_i) |=> (state_q == ST_IDLE));

    // R12: the sample strobe lasts a single cycle
    p_sample_single_r12: assert property (@(posedge clk) disable iff (!rst_n)
        sample_o |=> !sample_o);

    // R12: a sample strobe is always inside a conversion
    p_sample_in_conv_r12: assert property (@(posedge clk) disable iff (!rst_n)
        sample_o |-> convert_o);

    // R10: the flag is sticky until a clear pulse
    p_flag_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_o && !flag_clr_i) |=> flag_o);

    // R10: a clear with no simultaneous completion drops the interrupt
    p_clear_drops_irq_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_clr_i && !scan_done) |=> (!irq_o && !flag_o));

    // R8: an interrupt request never stands without the flag
    p_irq_needs_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> flag_o);

    // R7: the flag only rises after the last channel of the scan converted
    p_flag_rise_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_o) |-> $past(conv_end && ptr_last));

endmodule

// File: tb/adc_scan_sequencer_test.sv
`timescale 1ns/1ps
module adc_scan_sequencer_test;

    localparam int RES_W = 10;
    localparam int D     = 10;
    localparam int LS    = 266;
    localparam int LF    = 134;

    typedef struct packed {
        logic       grp;
        logic [1:0] size;
        logic       fast;
        logic       ien;
        logic [9:0] base;
    } vec_t;

    localparam vec_t VECS [4] = '{
        '{grp: 1'b0, size: 2'd3, fast: 1'b1, ien: 1'b1, base: 10'd100},
        '{grp: 1'b1, size: 2'd1, fast: 1'b0, ien: 1'b0, base: 10'd200},
        '{grp: 1'b1, size: 2'd0, fast: 1'b1, ien: 1'b1, base: 10'd300},
        '{grp: 1'b0, size: 2'd2, fast: 1'b0, ien: 1'b1, base: 10'd400}
    };

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start_i = 1'b0;
    logic             grp_sel_i = 1'b0;
    logic             clk_sel_i = 1'b0;
    logic             irq_en_i = 1'b0;
    logic [1:0]       scan_size_i = 2'd0;
    logic             flag_clr_i = 1'b0;
    logic             core_done_i;
    logic [RES_W-1:0] core_data_i;
    logic [2:0]       chan_o;
    logic             sample_o;
    logic             convert_o;
    logic             flag_o;
    logic             irq_o;
    logic [8*RES_W-1:0] results_o;

    int base_val = 0;
    int cyc = 0;
    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc++;

    // Converter core model: result = base + channel, valid after the sample cycle
    assign core_done_i = convert_o & ~sample_o;
    assign core_data_i = RES_W'(base_val) + RES_W'(chan_o);

    adc_scan_sequencer uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start_i),
        .grp_sel_i   (grp_sel_i),
        .clk_sel_i   (clk_sel_i),
        .irq_en_i    (irq_en_i),
        .scan_size_i (scan_size_i),
        .flag_clr_i  (flag_clr_i),
        .core_done_i (core_done_i),
        .core_data_i (core_data_i),
        .chan_o      (chan_o),
        .sample_o    (sample_o),
        .convert_o   (convert_o),
        .flag_o      (flag_o),
        .irq_o       (irq_o),
        .results_o   (results_o)
    );

    function automatic int res(input int ch);
        return int'(results_o[ch*RES_W +: RES_W]);
    endfunction

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic wait_to(input int target);
        while (cyc < target) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        start_i = 1'b0;
        flag_clr_i = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        #(190000 * 5);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 190000);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int t0;
        // R1: reset state
        do_reset();
        check("R1", "flag", int'(flag_o), 0);
        check("R1", "irq", int'(irq_o), 0);
        check("R1", "convert", int'(convert_o), 0);
        check("R1", "sample", int'(sample_o), 0);
        check("R1", "chan", int'(chan_o), 0);
        check("R1", "results", int'(results_o == '0), 1);

        // Vector table walk: R2..R9, R12
        for (int v = 0; v < 4; v++) begin
            int len, n, bch;
            do_reset();
            base_val    = int'(VECS[v].base);
            grp_sel_i   = VECS[v].grp;
            scan_size_i = VECS[v].size;
            clk_sel_i   = VECS[v].fast;
            irq_en_i    = VECS[v].ien;
            len = VECS[v].fast ? LF : LS;
            n   = int'(VECS[v].size) + 1;
            bch = VECS[v].grp ? 4 : 0;
            start_i = 1'b1;
            t0 = cyc;
            wait_to(t0 + D);
            check("R5", "no strobe during delay", int'(sample_o | convert_o), 0);
            wait_to(t0 + 1 + D);
            check("R12", "first sample", int'(sample_o), 1);
            check("R2", "start channel", int'(chan_o), bch);
            for (int j = 0; j < n; j++) begin
                int w;
                w = t0 + 1 + D + (j + 1) * len;
                wait_to(w - 1);
                check((j == 0) ? "R5" : "R6", "result not yet written", res(bch + j), 0);
                check("R3", "channel order", int'(chan_o), bch + j);
                check("R7", "flag before last", int'(flag_o), 0);
                wait_to(w);
                check("R4", "result written", res(bch + j), base_val + bch + j);
            end
            check("R7", "flag after last", int'(flag_o), 1);
            check("R8", "irq follows enable", int'(irq_o), int'(VECS[v].ien));
            check("R9", "wrap channel", int'(chan_o), bch);
            check("R12", "sample after wrap", int'(sample_o), 1);
            check("R9", "still converting", int'(convert_o), 1);
            start_i = 1'b0;
            @(negedge clk);
            check("R11", "stop ends conversion", int'(convert_o), 0);
            check("R10", "flag kept after stop", int'(flag_o), 1);
        end

        // R10: clear pulse drops flag and irq
        do_reset();
        base_val = 50; grp_sel_i = 1'b0; scan_size_i = 2'd0; clk_sel_i = 1'b1; irq_en_i = 1'b1;
        start_i = 1'b1;
        t0 = cyc;
        wait_to(t0 + 1 + D + LF);
        check("R7", "single channel flag", int'(flag_o), 1);
        start_i = 1'b0;
        repeat (20) @(negedge clk);
        check("R10", "flag sticky", int'(flag_o), 1);
        check("R10", "irq sticky", int'(irq_o), 1);
        flag_clr_i = 1'b1;
        @(negedge clk);
        flag_clr_i = 1'b0;
        check("R10", "flag cleared", int'(flag_o), 0);
        check("R10", "irq cleared", int'(irq_o), 0);

        // R11: abort mid-conversion, no write
        do_reset();
        base_val = 500; grp_sel_i = 1'b0; scan_size_i = 2'd0; clk_sel_i = 1'b1; irq_en_i = 1'b1;
        start_i = 1'b1;
        t0 = cyc;
        wait_to(t0 + 1 + D + 50);
        start_i = 1'b0;
        @(negedge clk);
        check("R11", "idle after abort", int'(convert_o), 0);
        wait_to(t0 + 1 + D + LF + 5);
        check("R11", "no write on abort", res(0), 0);
        check("R11", "no flag on abort", int'(flag_o), 0);

        // R11: abort during delay, then restart counts full delay (R5)
        start_i = 1'b1;
        t0 = cyc;
        wait_to(t0 + 3);
        start_i = 1'b0;
        repeat (D + 5) @(negedge clk);
        check("R11", "no conversion after delay abort", int'(convert_o | sample_o), 0);
        start_i = 1'b1;
        t0 = cyc;
        wait_to(t0 + 1 + D + LF - 1);
        check("R5", "restart waits full delay", res(0), 0);
        wait_to(t0 + 1 + D + LF);
        check("R5", "restart result", res(0), 500);
        start_i = 1'b0;
        @(negedge clk);

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule